// File: doc/BRIEF.md
# Byte Bus Decoder with RAM and Device Register Page

This block sits on a 16-bit byte-addressed bus driven by a processor-side master. One request is presented per clock. The request is made of an active-low select, a single read-not-write line, an address and a write byte. The block steers each request by address. Addresses in the low part of the space reach an internal byte RAM. Addresses in the top 4 KB page (0xF000 to 0xFFFF) reach a small file of 16-bit device registers, which are laid out at fixed addresses.

The device page holds three registers: a control/status word at 0xFE70 (octal 177160), a first data buffer at 0xFE72 (octal 177162) and a second data buffer at 0xFE74 (octal 177164). Each register is reached one byte at a time. The even address reaches the low byte and the odd address reaches the high byte. Any other address in the device page is unmapped. The RAM depth is a parameter. Addresses at or above that depth but below the device page form a hole.

Read results come back one clock after the request. They arrive with a one-cycle valid strobe and, for unmapped device-page reads, an error strobe. The bus has no back-pressure: the master may issue a request every cycle, and each read produces exactly one valid cycle.

Top module: `mmio_bus_decoder`

## Requirements
- R1: A read request (select low, read-not-write = 1) sampled at a rising edge makes `bus_rvalid` high for the following cycle, and back-to-back reads each return their own data in order.
- R2: A write to an address below `RAM_DEPTH` stores the byte, and a later read of the same address returns it.
- R3: An address from `RAM_DEPTH` up to 0xEFFF reads as zero without error, and a write to it changes no RAM byte.
- R4: The registers at 0xFE70, 0xFE72 and 0xFE74 are 16 bits wide. The even address accesses bits 7:0 and the odd address (base + 1) accesses bits 15:8. Each byte is written independently of all other bytes.
- R5: A read of any device-page address (0xF000 to 0xFFFF) other than the six register bytes returns zero and raises `bus_err` together with `bus_rvalid` for that one cycle. A write to such an address changes no register.
- R6: While select is high, nothing is written and `bus_rvalid` stays low in the next cycle.
- R7: After reset, all device registers read zero and `bus_rvalid`, `bus_err` and `bus_rdata` are zero.
- R8: Whenever `bus_rvalid` is low, `bus_rdata` is zero and `bus_err` is low.
- R9: A write request (select low, read-not-write = 0) produces no `bus_rvalid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel_n | input | 1 | Request select, active low |
| bus_rnw | input | 1 | 1 = read, 0 = write (used while select is low) |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with `bus_rvalid`, zero otherwise |
| bus_rvalid | output | 1 | One-cycle strobe, one clock after a read request |
| bus_err | output | 1 | Unmapped device-page read, qualified by `bus_rvalid` |

## Verification
The bench builds the block with `RAM_DEPTH` = 64. This makes every RAM byte, the RAM/hole boundary at 63/64 and the hole top at 0xEFFF cheap to visit. It also makes a stepped walk of the hole able to catch low-bit aliasing back into RAM. The whole 4096-byte device page is swept twice: first with writes of a marker byte to every unmapped address, then with reads of every address. Each read result, whether register byte, zero with error, or zero without, is predicted from the address arithmetically.

// File: rtl/mmio_pkg.sv
`timescale 1ns/1ps
package mmio_pkg;
  localparam int BYTE_W     = 8;
  localparam int BUS_AW     = 16;
  localparam logic [BUS_AW-1:0] IO_BASE  = 16'hF000;
  localparam logic [BUS_AW-1:0] DEV_BASE = 16'hFE70;
  localparam int DEV_COUNT  = 3;
  localparam int DEV_REG_W  = 16;
  localparam int DEV_LANES  = DEV_REG_W / BYTE_W;
  localparam int LANE_BITS  = (DEV_LANES > 1) ? $clog2(DEV_LANES) : 1;
  localparam int DEV_IDX_W  = (DEV_COUNT > 1) ? $clog2(DEV_COUNT) : 1;
  localparam int DEV_SPAN   = DEV_COUNT * DEV_LANES;

  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_HOLE = 2'd1,
    RGN_DEV  = 2'd2,
    RGN_BAD  = 2'd3
  } region_e;

  typedef struct packed {
    region_e                rgn;
    logic [DEV_IDX_W-1:0]   dev;
    logic [LANE_BITS-1:0]   lane;
  } target_t;
endpackage

// File: rtl/mmio_addr_decode.sv
`timescale 1ns/1ps
module mmio_addr_decode
  import mmio_pkg::*;
#(
  parameter int RAM_DEPTH = 256,
  parameter int RAM_AW    = $clog2(RAM_DEPTH)
) (
  input  logic [BUS_AW-1:0] addr,
  output target_t           tgt,
  output logic [RAM_AW-1:0] ram_idx
);
  logic [BUS_AW-1:0] dev_off;

  always_comb begin
    dev_off = addr - DEV_BASE;
    tgt     = '0;
    if (addr >= IO_BASE) begin
      if ((addr >= DEV_BASE) && (32'(dev_off) < DEV_SPAN)) begin
        tgt.rgn  = RGN_DEV;
        tgt.dev  = dev_off[LANE_BITS +: DEV_IDX_W];
        tgt.lane = dev_off[LANE_BITS-1:0];
      end else begin
        tgt.rgn = RGN_BAD;
      end
    end else if (32'(addr) < RAM_DEPTH) begin
      tgt.rgn = RGN_RAM;
    end else begin
      tgt.rgn = RGN_HOLE;
    end
  end

  assign ram_idx = addr[RAM_AW-1:0];
endmodule

// File: rtl/mmio_byte_ram.sv
`timescale 1ns/1ps
module mmio_byte_ram
  import mmio_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rd_q <= mem[idx];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/mmio_dev_regs.sv
`timescale 1ns/1ps
module mmio_dev_regs
  import mmio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [DEV_IDX_W-1:0] dev,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [BYTE_W-1:0]    rdata
);
  logic [DEV_REG_W-1:0] regs [DEV_COUNT];
  logic [DEV_REG_W-1:0] word_sel;
  logic [BYTE_W-1:0]    byte_sel;
  logic [BYTE_W-1:0]    rd_q;

  for (genvar g = 0; g < DEV_COUNT; g++) begin : g_reg
    for (genvar l = 0; l < DEV_LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[g][l*BYTE_W +: BYTE_W] <= '0;
        else if (wr_en && (dev == DEV_IDX_W'(g)) && (lane == LANE_BITS'(l)))
          regs[g][l*BYTE_W +: BYTE_W] <= wdata;
      end
    end

    // R4: a register not addressed by a write keeps its value
    p_dev_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (dev == DEV_IDX_W'(g))) |=> $stable(regs[g]));
  end

  always_comb begin
    word_sel = '0;
    for (int i = 0; i < DEV_COUNT; i++)
      if (dev == DEV_IDX_W'(i)) word_sel = regs[i];
    byte_sel = '0;
    for (int j = 0; j < DEV_LANES; j++)
      if (lane == LANE_BITS'(j)) byte_sel = word_sel[j*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= byte_sel;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/mmio_bus_decoder.sv
`timescale 1ns/1ps
module mmio_bus_decoder
  import mmio_pkg::*;
#(
  parameter int RAM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_rnw,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  target_t           tgt;
  logic [RAM_AW-1:0] ram_idx;
  logic              req_rd, req_wr;
  logic [7:0]        ram_rd, dev_rd;
  logic              valid_q;
  region_e           rgn_q;

  assign req_rd = !bus_sel_n &&  bus_rnw;
  assign req_wr = !bus_sel_n && !bus_rnw;

  mmio_addr_decode #(.RAM_DEPTH(RAM_DEPTH), .RAM_AW(RAM_AW)) u_dec (
    .addr    (bus_addr),
    .tgt     (tgt),
    .ram_idx (ram_idx)
  );

  mmio_byte_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .wr_en (req_wr && (tgt.rgn == RGN_RAM)),
    .rd_en (req_rd && (tgt.rgn == RGN_RAM)),
    .idx   (ram_idx),
    .wdata (bus_wdata),
    .rdata (ram_rd)
  );

  mmio_dev_regs u_dev (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (req_wr && (tgt.rgn == RGN_DEV)),
    .rd_en (req_rd && (tgt.rgn == RGN_DEV)),
    .dev   (tgt.dev),
    .lane  (tgt.lane),
    .wdata (bus_wdata),
    .rdata (dev_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rgn_q   <= RGN_HOLE;
    end else begin
      valid_q <= req_rd;
      if (req_rd) rgn_q <= tgt.rgn;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (valid_q) begin
      case (rgn_q)
        RGN_RAM: bus_rdata = ram_rd;
        RGN_DEV: bus_rdata = dev_rd;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign bus_rvalid = valid_q;
  assign bus_err    = valid_q && (rgn_q == RGN_BAD);

  p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel_n && bus_rnw) |=> bus_rvalid);
  p_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel_n && !bus_rnw) |=> !bus_rvalid);
  p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel_n |=> !bus_rvalid);
  p_err_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rvalid);
  p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> (bus_rdata == 8'h00 && !bus_err));
  p_dev_page_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel_n && bus_rnw && bus_addr < IO_BASE) |=> !bus_err);
endmodule

// File: tb/mmio_bus_decoder_test.sv
`timescale 1ns/1ps
module mmio_bus_decoder_test;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, rnw = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, err;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_dev [3];

  always #10 clk = ~clk;

  mmio_bus_decoder #(.RAM_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_rnw(rnw),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_rvalid(rvalid), .bus_err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ram_pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic int dev_slot(input int a);
    if (a >= 16'hFE70 && a < 16'hFE76) return (a - 16'hFE70) / 2;
    return -1;
  endfunction

  task automatic wr(input int a, input logic [7:0] d, input bit check_r9);
    @(negedge clk);
    sel_n = 1'b0; rnw = 1'b0; addr = 16'(a); wdata = d;
    @(negedge clk);
    sel_n = 1'b1;
    if (check_r9) chk(rvalid == 1'b0, "R9 write valid", int'(rvalid), 0);
  endtask

  task automatic rd(input int a, output logic [7:0] d, output logic v, output logic e);
    @(negedge clk);
    sel_n = 1'b0; rnw = 1'b1; addr = 16'(a);
    @(negedge clk);
    sel_n = 1'b1;
    d = rdata; v = rvalid; e = err;
  endtask

  function automatic logic [7:0] dev_byte(input int a);
    int s;
    s = dev_slot(a);
    return (a % 2 == 1) ? m_dev[s][15:8] : m_dev[s][7:0];
  endfunction

  initial begin
    #4000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v; logic e;
    for (int i = 0; i < 3; i++) m_dev[i] = '0;
    repeat (3) @(negedge clk);
    chk(rvalid == 0 && err == 0 && rdata == 0, "R7 reset outputs", {rdata, 1'b0, rvalid, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 16'hFE70; a < 16'hFE76; a++) begin
      rd(a, d, v, e);
      chk(v && !e && d == 0, "R7 reset register", d, 0);
    end

    // R2: every RAM byte
    for (int a = 0; a < DEPTH; a++) wr(a, ram_pat(a), 0);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, d, v, e);
      chk(v && !e && d == ram_pat(a), "R2 ram readback", d, ram_pat(a));
    end

    // R3: hole writes ignored, reads zero, no aliasing into RAM
    for (int a = DEPTH; a <= 16'hEFFF; a += 211) begin
      wr(a, 8'h5A, 1);
      rd(a, d, v, e);
      chk(v && !e && d == 0, "R3 hole read", d, 0);
    end
    wr(16'hEFFF, 8'h77, 0);
    rd(16'hEFFF, d, v, e);
    chk(v && !e && d == 0, "R3 hole top", d, 0);
    rd(DEPTH, d, v, e);
    chk(v && !e && d == 0, "R3 hole bottom", d, 0);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, d, v, e);
      chk(d == ram_pat(a), "R3 ram untouched", d, ram_pat(a));
    end

    // R4: byte lanes of the three registers
    for (int a = 16'hFE70; a < 16'hFE76; a++) begin
      int s;
      logic [7:0] b;
      s = dev_slot(a);
      b = 8'((a * 29 + 5) & 255);
      if (a % 2 == 1) m_dev[s][15:8] = b; else m_dev[s][7:0] = b;
      wr(a, b, 1);
    end
    for (int a = 16'hFE70; a < 16'hFE76; a++) begin
      rd(a, d, v, e);
      chk(v && !e && d == dev_byte(a), "R4 register byte", d, dev_byte(a));
    end
    wr(16'hFE73, 8'hE1, 0); m_dev[1][15:8] = 8'hE1;
    for (int a = 16'hFE70; a < 16'hFE76; a++) begin
      rd(a, d, v, e);
      chk(d == dev_byte(a), "R4 single lane write", d, dev_byte(a));
    end

    // R5: write marker to all unmapped device-page bytes, then sweep reads
    for (int a = 16'hF000; a <= 16'hFFFF; a++)
      if (dev_slot(a) < 0) wr(a, 8'hC3, 0);
    for (int a = 16'hF000; a <= 16'hFFFF; a++) begin
      rd(a, d, v, e);
      if (dev_slot(a) >= 0)
        chk(v && !e && d == dev_byte(a), "R5 mapped byte kept", d, dev_byte(a));
      else
        chk(v && e && d == 0, "R5 unmapped read", {d, 3'b0, e}, 1);
    end

    // R6: select high with write and read levels
    @(negedge clk);
    sel_n = 1'b1; rnw = 1'b0; addr = 16'hFE70; wdata = 8'hEE;
    @(negedge clk);
    chk(rvalid == 0, "R6 idle write level", rvalid, 0);
    rnw = 1'b1; addr = 16'h0005;
    @(negedge clk);
    chk(rvalid == 0 && rdata == 0, "R6 idle read level", rvalid, 0);
    rd(16'hFE70, d, v, e);
    chk(d == dev_byte(16'hFE70), "R6 register unchanged", d, dev_byte(16'hFE70));

    // R1: back-to-back reads
    @(negedge clk);
    sel_n = 1'b0; rnw = 1'b1; addr = 16'h0003;
    @(negedge clk);
    addr = 16'hFE74;
    chk(rvalid && rdata == ram_pat(3), "R1 first of pair", rdata, ram_pat(3));
    @(negedge clk);
    addr = 16'hF100;
    chk(rvalid && !err && rdata == dev_byte(16'hFE74), "R1 second of pair", rdata, dev_byte(16'hFE74));
    @(negedge clk);
    sel_n = 1'b1;
    chk(rvalid && err && rdata == 0, "R1 third of run", {rdata, 3'b0, err}, 1);
    @(negedge clk);
    chk(!rvalid && !err && rdata == 0, "R8 quiet after run", rdata, 0);

    // R7: reset returns registers to zero
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) m_dev[i] = '0;
    rd(16'hFE75, d, v, e);
    chk(v && d == 0, "R7 reset clears register", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule